// File: doc/BRIEF.md
# Serial Attenuator Word Programmer

This block is the host-side controller for a step attenuator that takes its setting over a three-wire serial link. A requester offers a 6-bit attenuation code on a valid/ready handshake. The code counts in half-dB steps, so its top bit is the 16 dB weight and its bottom bit is the 0.5 dB weight. The block then drives the link itself. The link has a data line, a shift clock, and a latch strobe that loads the shifted word into the attenuator.

All of the link timing comes from the system clock. Parameters set, in system-clock cycles, how long the shift clock stays low and high, how long the block waits between the last shift edge and the strobe, and how long the strobe is held high. A further parameter gives the system clock period. With it, a checker confirms at elaboration that every interval meets the attenuator's limits in nanoseconds. While a word is in flight the block shows busy and refuses new requests. When the strobe has closed, it raises a one-cycle done pulse.

Top module: `atten_word_prog`

## Requirements
- R1: After reset, and whenever idle, the shift clock, the latch strobe and the data line are all low; busy is low and req_ready is high.
- R2: An accepted code goes out as six bits, bit 5 (16 dB) first and bit 0 (0.5 dB) last. The attenuator takes each bit on a shift-clock rising edge, and exactly six rising edges occur per word, so the word latched equals the requested code.
- R3: The shift clock is high for at least HIGH_CYC cycles (≥30 ns) and low for at least LOW_CYC cycles (≥30 ns), and its rising edges within a word are at least 100 ns apart.
- R4: The data line changes only while the shift clock is low. It is stable for at least 10 ns before and at least 10 ns after every rising edge.
- R5: The latch strobe stays low while bits are shifted. It rises no earlier than HIGH_CYC+GAP_CYC cycles (≥10 ns) after the last rising edge.
- R6: The latch strobe is high for exactly LE_PW_CYC cycles, which must be at least 30 ns.
- R7: req_ready is high only while idle. A request offered while busy is ignored and never produces an extra latch.
- R8: done is high for exactly one cycle, the first cycle in which the strobe is low again after its pulse.
- R9: busy stays high for exactly 6·(LOW_CYC+HIGH_CYC)+GAP_CYC+LE_PW_CYC cycles per accepted word.
- R10: Elaboration checks compare every interval parameter, multiplied by SYS_PERIOD_PS, against its minimum in nanoseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_word | input | 6 | Attenuation code in half-dB steps |
| busy | output | 1 | Word transfer in progress |
| done | output | 1 | One-cycle pulse after the latch strobe closes |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Serial shift clock |
| ser_le | output | 1 | Latch strobe |

## Verification
The bench builds the block with a 10 ns system clock, HIGH_CYC=3, LOW_CYC=7, GAP_CYC=1 and LE_PW_CYC=3. With these values the clock high time sits exactly on its 30 ns minimum and the shift period exactly on its 100 ns limit, so a one-cycle loss in any phase breaks a measured limit. The strobe setup is only one cycle above the last clock high phase. Codes with alternating bits, all ones, all zeros and single set bits at each end expose ordering and shift errors. A request held through a transfer checks that such requests are refused.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH
  } prog_state_t;

  // attenuator limits, picoseconds
  localparam int unsigned MIN_CLK_HIGH_PS = 30000;
  localparam int unsigned MIN_CLK_LOW_PS  = 30000;
  localparam int unsigned MIN_CLK_PER_PS  = 100000;
  localparam int unsigned MIN_SETUP_PS    = 10000;
  localparam int unsigned MIN_HOLD_PS     = 10000;
  localparam int unsigned MIN_LE_SU_PS    = 10000;
  localparam int unsigned MIN_LE_PW_PS    = 30000;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/atten_word_shifter.sv
module atten_word_shifter #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              next_bit
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_word;
    else if (shift) sr <= {sr[WORD_W-2:0], 1'b0};
  end

  // bit that follows the one now on the line
  assign next_bit = sr[WORD_W-2];
endmodule

// File: rtl/atten_word_prog.sv
module atten_word_prog #(
  parameter int WORD_W        = 6,
  parameter int SYS_PERIOD_PS = 10000,
  parameter int HIGH_CYC      = 4,
  parameter int LOW_CYC       = 6,
  parameter int GAP_CYC       = 1,
  parameter int LE_PW_CYC     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_word,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le
);
  import atten_prog_pkg::*;

  localparam int MAX_CYC = max4(HIGH_CYC, LOW_CYC, GAP_CYC, LE_PW_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam int BIT_W   = $clog2(WORD_W);

  localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LD   = CNT_W'(LE_PW_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_IX = BIT_W'(WORD_W - 1);

  prog_state_t       state, state_nxt;
  logic [BIT_W-1:0]  bits_left;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              sh_load, sh_shift, sh_next;
  logic              accept;

  assign accept = req_valid && (state == ST_IDLE);

  atten_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  atten_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_word (req_word),
    .shift     (sh_shift),
    .next_bit  (sh_next)
  );

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        sh_load = 1'b1; tmr_load = 1'b1; tmr_val = LOW_LD; state_nxt = ST_LOW;
      end
      ST_LOW: if (tmr_done) begin
        tmr_load = 1'b1; tmr_val = HIGH_LD; state_nxt = ST_HIGH;
      end
      ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        if (bits_left == '0) begin
          tmr_val = GAP_LD; state_nxt = ST_GAP;
        end else begin
          tmr_val = LOW_LD; sh_shift = 1'b1; state_nxt = ST_LOW;
        end
      end
      ST_GAP: if (tmr_done) begin
        tmr_load = 1'b1; tmr_val = PW_LD; state_nxt = ST_LATCH;
      end
      ST_LATCH: if (tmr_done) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      ser_data  <= 1'b0;
      ser_clk   <= 1'b0;
      ser_le    <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          ser_data  <= req_word[WORD_W-1];
          bits_left <= LAST_IX;
        end
        ST_LOW:  if (tmr_done) ser_clk <= 1'b1;
        ST_HIGH: if (tmr_done) begin
          ser_clk <= 1'b0;
          if (bits_left == '0) ser_data <= 1'b0;
          else begin
            ser_data  <= sh_next;
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_GAP:  if (tmr_done) ser_le <= 1'b1;
        ST_LATCH: if (tmr_done) begin
          ser_le <= 1'b0;
          done   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/atten_word_prog_chk.sv
module atten_word_prog_chk #(
  parameter int WORD_W        = 6,
  parameter int SYS_PERIOD_PS = 10000,
  parameter int HIGH_CYC      = 4,
  parameter int LOW_CYC       = 6,
  parameter int GAP_CYC       = 1,
  parameter int LE_PW_CYC     = 3
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_le
);
  import atten_prog_pkg::*;

  // R10: interval parameters against the attenuator limits
  initial begin
    a_high_r10:  assert (HIGH_CYC * SYS_PERIOD_PS >= MIN_CLK_HIGH_PS) else $error("R10 clock high too short");
    a_low_r10:   assert (LOW_CYC * SYS_PERIOD_PS >= MIN_CLK_LOW_PS) else $error("R10 clock low too short");
    a_per_r10:   assert ((HIGH_CYC + LOW_CYC) * SYS_PERIOD_PS >= MIN_CLK_PER_PS) else $error("R10 shift period too short");
    a_su_r10:    assert (LOW_CYC * SYS_PERIOD_PS >= MIN_SETUP_PS) else $error("R10 data setup too short");
    a_hold_r10:  assert (HIGH_CYC * SYS_PERIOD_PS >= MIN_HOLD_PS) else $error("R10 data hold too short");
    a_lesu_r10:  assert (GAP_CYC >= 1 && (HIGH_CYC + GAP_CYC) * SYS_PERIOD_PS >= MIN_LE_SU_PS) else $error("R10 strobe setup too short");
    a_lepw_r10:  assert (LE_PW_CYC * SYS_PERIOD_PS >= MIN_LE_PW_PS) else $error("R10 strobe pulse too short");
  end

  logic        clk_q, le_q;
  logic [15:0] hi_run, lo_run, le_run, since_rise;
  logic [7:0]  rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0; le_q <= 1'b0;
      hi_run <= '0; lo_run <= '0; le_run <= '0; since_rise <= 16'hFFFF;
      rise_cnt <= '0;
    end else begin
      clk_q  <= ser_clk;
      le_q   <= ser_le;
      hi_run <= ser_clk ? hi_run + 1'b1 : '0;
      lo_run <= (!ser_clk && lo_run != 16'hFFFF) ? lo_run + 1'b1 : (ser_clk ? '0 : lo_run);
      le_run <= ser_le ? le_run + 1'b1 : '0;
      if (ser_clk && !clk_q)          since_rise <= 16'd1;
      else if (since_rise != 16'hFFFF) since_rise <= since_rise + 1'b1;
      if (!ser_le && le_q)            rise_cnt <= '0;
      else if (ser_clk && !clk_q)     rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_le && !ser_data));
  p_six_edges_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_le) |-> (rise_cnt == 8'(WORD_W)));
  p_clk_high_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> (hi_run >= 16'(HIGH_CYC)));
  p_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> (lo_run >= 16'(LOW_CYC)));
  p_data_in_low_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> !ser_clk);
  p_data_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data));
  p_le_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> !ser_le);
  p_le_setup_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_le) |-> (since_rise >= 16'(HIGH_CYC + GAP_CYC)));
  p_le_width_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_le) |-> (le_run == 16'(LE_PW_CYC)));
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && !req_ready));
  p_done_at_fall_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ser_le && le_q));
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind atten_word_prog atten_word_prog_chk #(
  .WORD_W(WORD_W), .SYS_PERIOD_PS(SYS_PERIOD_PS), .HIGH_CYC(HIGH_CYC),
  .LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC), .LE_PW_CYC(LE_PW_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le)
);

// File: tb/atten_word_prog_tb.sv
module atten_word_prog_tb;
  localparam int W    = 6;
  localparam int PER  = 10000;
  localparam int HC   = 3;
  localparam int LC   = 7;
  localparam int GC   = 1;
  localparam int PC   = 3;
  localparam int EXP_BUSY = W * (LC + HC) + GC + PC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [W-1:0] req_word = '0;
  logic req_ready, busy, done, ser_data, ser_clk, ser_le;

  always #5 clk = ~clk;

  atten_word_prog #(.WORD_W(W), .SYS_PERIOD_PS(PER), .HIGH_CYC(HC),
                    .LOW_CYC(LC), .GAP_CYC(GC), .LE_PW_CYC(PC)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .busy(busy), .done(done), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_le(ser_le));

  int n_chk = 0;
  int n_err = 0;
  int n_latch = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: offer one code when idle, push the expected latch
  task automatic send(input logic [W-1:0] w);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_word  = w;
    exp_q.push_back(w);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: attenuator model plus interval measurement, sampled mid-cycle
  logic [W-1:0] model_sr = '0;
  logic pclk = 0, ple = 0, pdata = 0, pdone = 0, pbusy = 0;
  int cyc = 0, last_rise = -1000, last_fall = -1000, last_chg = -1000;
  int le_rise = -1000, nrise = 0, busy_run = 0, min_high = 1000;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (ser_data !== pdata) begin
        chk(!ser_clk, "R4", "data moved while clock high", 1, 0);
        chk((cyc - last_rise) * PER >= 10000, "R4", "hold ps", (cyc - last_rise) * PER, 10000);
        last_chg = cyc;
      end
      if (ser_clk && !pclk) begin
        chk(!ser_le, "R5", "strobe high at shift edge", 1, 0);
        chk((cyc - last_chg) * PER >= 10000, "R4", "setup ps", (cyc - last_chg) * PER, 10000);
        chk((cyc - last_fall) * PER >= 30000, "R3", "low ps", (cyc - last_fall) * PER, 30000);
        if (nrise > 0)
          chk((cyc - last_rise) * PER >= 100000, "R3", "period ps", (cyc - last_rise) * PER, 100000);
        model_sr = {model_sr[W-2:0], ser_data};
        nrise++;
        last_rise = cyc;
      end
      if (!ser_clk && pclk) begin
        chk((cyc - last_rise) * PER >= 30000, "R3", "high ps", (cyc - last_rise) * PER, 30000);
        if (cyc - last_rise < min_high) min_high = cyc - last_rise;
        last_fall = cyc;
      end
      if (ser_le && !ple) begin
        chk((cyc - last_rise) * PER >= 10000, "R5", "strobe setup ps", (cyc - last_rise) * PER, 10000);
        chk(nrise == W, "R2", "shift edges", nrise, W);
        le_rise = cyc;
      end
      if (!ser_le && ple) begin
        chk((cyc - le_rise) == PC, "R6", "strobe width cycles", cyc - le_rise, PC);
        chk(done === 1'b1, "R8", "done at strobe fall", done, 1);
        n_latch++;
        if (exp_q.size() == 0) chk(1'b0, "R7", "latch with no request", model_sr, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(model_sr == e, "R2", "latched word", model_sr, e);
        end
        nrise = 0;
      end else if (done) chk(1'b0, "R8", "done without strobe fall", 1, 0);
      if (pdone) chk(done === 1'b0, "R8", "done width", done, 0);
      if (busy) busy_run++;
      if (!busy && pbusy) begin
        chk(busy_run == EXP_BUSY, "R9", "busy cycles", busy_run, EXP_BUSY);
        busy_run = 0;
      end
      pclk = ser_clk; ple = ser_le; pdata = ser_data; pdone = done; pbusy = busy;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit rdy_low;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset levels
    chk(!ser_clk && !ser_le && !ser_data, "R1", "link idle after reset", {ser_clk, ser_le, ser_data}, 0);
    chk(!busy && req_ready, "R1", "ready after reset", {busy, req_ready}, 1);

    send(6'h00); send(6'h3F); send(6'h2A);
    send(6'h15); send(6'h20); send(6'h01);

    // R7: request held while busy must be refused
    send(6'h0C);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_word = 6'h33;
    rdy_low = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (req_ready) rdy_low = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rdy_low, "R7", "ready low while busy", !rdy_low, 0);
    while (busy) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(n_latch == 7, "R7", "latch count", n_latch, 7);
    chk(exp_q.size() == 0, "R2", "words left unlatched", exp_q.size(), 0);
    chk(!ser_clk && !ser_le && !ser_data && req_ready, "R1", "idle after traffic",
        {ser_clk, ser_le, ser_data, req_ready}, 1);
    // R10: the configured high phase is exactly what the link shows
    chk(min_high == HC, "R10", "shortest high phase cycles", min_high, HC);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule